// File: doc/BRIEF.md
# PRBS Error Rate Monitor

This block measures the bit error rate of a received pseudo-random test pattern. Payload bits arrive one per strobe. A small state machine first aligns a local 15-stage linear feedback shift register to the incoming stream. It then free-runs that register and compares every new bit against it. Each mismatch adds one to an 8-bit error counter. A second 8-bit counter advances on each received CRC-4 multiframe start strobe and so gives the length of the measurement window.

Software works through a byte-wide register port with a combinational read path. Writing the error counter restarts the window: the written value goes into the error counter and the multiframe counter returns to zero in the same clock. The multiframe counter can also be loaded directly. When the error counter rolls over, a sticky overflow flag is set. The interrupt line shows that flag gated by a mask bit. Reading the flag register clears the flag.

The state machine has two states. SEEK is the state after reset. In it each valid bit is shifted into the register and a run of consecutive matches is counted. A mismatch takes the "restart" transition, SEEK to SEEK with the run at zero. The fifteenth consecutive match takes the "run_done" transition to LOCK. LOCK has a single "hold" transition back to itself. It is left only by reset.

Top module: `prbs_rate_mon`

## Requirements
- R1: After reset both counters, the overflow flag and the mask bit read zero, `irq` is low and the checker is in SEEK.
- R2: In SEEK every valid bit is shifted into the history register. A bit "matches" when it equals the XOR of the bits received 15 and 14 valid strobes earlier, with bits before reset taken as zero. A mismatch sets the run to zero. The checker enters LOCK on the valid bit that completes 15 consecutive matches, and stays there until reset.
- R3: In LOCK the register free-runs on its own prediction. Each valid bit that differs from the prediction adds exactly one to the error counter, so an isolated flipped bit counts once.
- R4: Bits received in SEEK, and cycles with `bit_valid` low, leave the error counter unchanged.
- R5: Each `mf_start` pulse adds one to the multiframe counter. Both counters roll from FFh to 00h and never saturate.
- R6: Writing address 1 loads the multiframe counter. Writing address 0 loads the error counter and clears the multiframe counter to zero. A write takes priority over an increment of the same counter in the same cycle.
- R7: A rollover of the error counter by an increment sets bit 0 of address 2, and bits 7:1 read zero. The flag stays set until a read strobe at address 2 clears it. If a rollover happens in the same cycle as that read, the flag stays set.
- R8: `irq` equals the overflow flag AND the mask bit. The mask bit is bit 0 of address 3, which can be read and written. Changing the mask does not clear the flag.
- R9: `reg_rdata` reflects `reg_addr` in the same cycle: 0 is the error counter, 1 the multiframe counter, 2 the flag register, 3 the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Received payload bit |
| mf_start | input | 1 | One-cycle pulse per received CRC-4 multiframe |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag at address 2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit counter width, a 15-stage register with taps 15 and 14, and a lock run of 15. With these values lock is reached about fifty bits after a partly corrupted start. Because the counters can be preloaded through the port, each rollover is only one or two events away. That makes the overflow flag, the read-clear race and the write-over-increment priority reachable in a short run.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

    typedef enum logic [0:0] {
        ST_SEEK = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_t;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] RA_ERR = 2'd0;
    localparam logic [REG_AW-1:0] RA_MFC = 2'd1;
    localparam logic [REG_AW-1:0] RA_OVF = 2'd2;
    localparam logic [REG_AW-1:0] RA_MSK = 2'd3;

endpackage

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
    import prbs_mon_pkg::*;
#(
    parameter int LFSR_W   = 15,
    parameter int TAP_HI   = 15,
    parameter int TAP_LO   = 14,
    parameter int LOCK_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic bit_err
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

    sync_state_t      state_q, state_d;
    logic [LFSR_W-1:0] hist_q;
    logic [RUN_W-1:0]  run_q;
    logic              pred;
    logic              match;
    logic              shift_bit;

    assign pred  = hist_q[TAP_HI-1] ^ hist_q[TAP_LO-1];
    assign match = (bit_in == pred);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: restart / run_done / hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: begin
                if (bit_valid && match && (run_q == RUN_LAST)) begin
                    state_d = ST_LOCK;
                end
            end
            ST_LOCK: begin
                state_d = ST_LOCK;
            end
        endcase
    end

    // outputs of the state machine
    always_comb begin
        bit_err   = 1'b0;
        shift_bit = bit_in;
        unique case (state_q)
            ST_SEEK: begin
                shift_bit = bit_in;
            end
            ST_LOCK: begin
                shift_bit = pred;
                bit_err   = bit_valid && !match;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (bit_valid) begin
            hist_q <= {hist_q[LFSR_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_valid && (state_q == ST_SEEK)) begin
            run_q <= match ? (run_q + RUN_W'(1)) : '0;
        end
    end

    // R2: once locked, the checker stays locked
    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |=> (state_q == ST_LOCK));

    // R2: lock is entered only from a run one short of the target
    p_lock_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LOCK) |-> ($past(run_q) == RUN_LAST));

    // R2: the run never exceeds the lock target
    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(LOCK_RUN));

    // R4: no error is reported while seeking
    p_seek_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEEK) |-> !bit_err);

endmodule

// File: rtl/prbs_wrap_counter.sv
module prbs_wrap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

    assign wrap = inc && !load && (count == CNT_MAX);

    // R3, R5: an increment adds exactly one, wrapping
    p_inc_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (count == $past(count) + W'(1)));

    // R4: without load or increment the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(count));

    // R6: a load wins over an increment
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

endmodule

// File: rtl/prbs_reg_port.sv
module prbs_reg_port
    import prbs_mon_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              mask_wbit,
    input  logic [DW-1:0]     err_count,
    input  logic [DW-1:0]     mf_count,
    input  logic              err_wrap,
    output logic              err_load,
    output logic              mf_load,
    output logic [DW-1:0]     rdata,
    output logic              irq
);

    logic ovf_q;
    logic mask_q;
    logic ovf_rd;

    assign err_load = reg_wr && (reg_addr == RA_ERR);
    assign mf_load  = reg_wr && ((reg_addr == RA_MFC) || (reg_addr == RA_ERR));
    assign ovf_rd   = reg_rd && (reg_addr == RA_OVF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (err_wrap) begin
            ovf_q <= 1'b1;
        end else if (ovf_rd) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (reg_wr && (reg_addr == RA_MSK)) begin
            mask_q <= mask_wbit;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_addr)
            RA_ERR: rdata = err_count;
            RA_MFC: rdata = mf_count;
            RA_OVF: rdata = {{(DW-1){1'b0}}, ovf_q};
            RA_MSK: rdata = {{(DW-1){1'b0}}, mask_q};
        endcase
    end

    assign irq = ovf_q && mask_q;

    // R7: a rollover always leaves the flag set
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_wrap |=> ovf_q);

    // R7: the flag is sticky without a clearing read
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_rd) |=> ovf_q);

    // R7: a clearing read without a rollover drops the flag
    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_rd && !err_wrap) |=> !ovf_q);

    // R8: a mask write leaves the flag alone
    p_mask_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == RA_MSK) && !err_wrap && ovf_q) |=> ovf_q);

endmodule

// File: rtl/prbs_rate_mon.sv
module prbs_rate_mon
    import prbs_mon_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LFSR_W   = 15,
    parameter int TAP_HI   = 15,
    parameter int TAP_LO   = 14,
    parameter int LOCK_RUN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             mf_start,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    logic             bit_err;
    logic             err_load;
    logic             mf_load;
    logic             err_wrap;
    logic             mf_wrap_unused;
    logic [CNT_W-1:0] err_count;
    logic [CNT_W-1:0] mf_count;
    logic [CNT_W-1:0] mf_load_val;

    assign mf_load_val = (reg_addr == RA_MFC) ? reg_wdata : '0;

    prbs_lock_fsm #(
        .LFSR_W  (LFSR_W),
        .TAP_HI  (TAP_HI),
        .TAP_LO  (TAP_LO),
        .LOCK_RUN(LOCK_RUN)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .bit_err  (bit_err)
    );

    prbs_wrap_counter #(.W(CNT_W)) u_err_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (bit_err),
        .load    (err_load),
        .load_val(reg_wdata),
        .count   (err_count),
        .wrap    (err_wrap)
    );

    prbs_wrap_counter #(.W(CNT_W)) u_mf_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (mf_start),
        .load    (mf_load),
        .load_val(mf_load_val),
        .count   (mf_count),
        .wrap    (mf_wrap_unused)
    );

    prbs_reg_port #(.DW(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .mask_wbit(reg_wdata[0]),
        .err_count(err_count),
        .mf_count (mf_count),
        .err_wrap (err_wrap),
        .err_load (err_load),
        .mf_load  (mf_load),
        .rdata    (reg_rdata),
        .irq      (irq)
    );

    // R6: writing the error counter restarts the multiframe window
    p_err_wr_clears_mf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == RA_ERR)) |=> (mf_count == '0));

    // R8: an interrupt always has a flag behind it
    p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (u_regs.ovf_q == 1'b1));

endmodule

// File: tb/test_prbs_rate_mon.sv
module test_prbs_rate_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       mf_start = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;

    // bench-side model of the pattern source and of the lock rule
    logic [14:0] gen_s = 15'h6B5D;
    logic [14:0] m_hist = '0;
    int          m_run = 0;
    bit          m_lock = 0;
    logic [7:0]  m_err = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    prbs_rate_mon i_prbs_rate_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .mf_start (mf_start),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    // {write, addr[1:0], data[7:0], expect[7:0]}
    localparam logic [18:0] VEC [0:9] = '{
        {1'b1, 2'd3, 8'h01, 8'h00},   // R8 set mask
        {1'b0, 2'd3, 8'h00, 8'h01},   // R8 R9 read mask
        {1'b1, 2'd1, 8'h37, 8'h00},   // R6 load multiframe count
        {1'b0, 2'd1, 8'h00, 8'h37},   // R6 R9
        {1'b1, 2'd0, 8'h5A, 8'h00},   // R6 load error count
        {1'b0, 2'd0, 8'h00, 8'h5A},   // R6 R9
        {1'b0, 2'd1, 8'h00, 8'h00},   // R6 window restarted
        {1'b0, 2'd2, 8'h00, 8'h00},   // R7 no flag yet
        {1'b1, 2'd3, 8'h00, 8'h00},   // R8 clear mask
        {1'b0, 2'd3, 8'h00, 8'h00}    // R8 R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic gen_bit();
        logic nb;
        nb = gen_s[14] ^ gen_s[13];
        gen_s = {gen_s[13:0], nb};
        return nb;
    endfunction

    // returns 1 when the bit is counted as an error
    function automatic bit model_step(input logic b);
        logic p;
        bit   e;
        p = m_hist[14] ^ m_hist[13];
        e = 0;
        if (!m_lock) begin
            m_run  = (b == p) ? m_run + 1 : 0;
            m_hist = {m_hist[13:0], b};
            if (m_run == 15) m_lock = 1;
        end else begin
            e      = (b != p);
            m_hist = {m_hist[13:0], p};
        end
        return e;
    endfunction

    // one clock: entered and left just after a falling edge
    task automatic cyc(input logic vb, input logic flip, input logic mf,
                       input logic wr, input logic rd, input logic [1:0] a,
                       input logic [7:0] d, output logic [7:0] rdv);
        bit e;
        e = 0;
        bit_valid = vb; mf_start = mf; reg_wr = wr; reg_rd = rd;
        reg_addr = a; reg_wdata = d;
        if (vb) begin
            bit_in = gen_bit() ^ flip;
            e = model_step(bit_in);
        end else begin
            bit_in = flip;
        end
        if (wr && a == 2'd0) m_err = d;
        else if (e) m_err = m_err + 8'h01;
        #1 rdv = reg_rdata;
        @(negedge clk);
        bit_valid = 0; mf_start = 0; reg_wr = 0; reg_rd = 0; bit_in = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        cyc(0, 0, 0, 0, 1, a, 8'h00, v);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] x;
        cyc(0, 0, 0, 1, 0, a, d, x);
    endtask

    task automatic bits(input int n, input logic flip);
        logic [7:0] x;
        for (int i = 0; i < n; i++) cyc(1, flip, 0, 0, 0, 2'd0, 8'h00, x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 address decode
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset register", v, 8'h00);
        end
        tests++;
        if (irq !== 1'b0) begin
            fails++;
            $display("FAIL R1 irq actual %0b expected 0", irq);
        end

        // register vector table
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][18]) begin
                wr(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][17:16], v);
                check($sformatf("R9 vector %0d", i), v, VEC[i][7:0]);
            end
        end

        // R2 R4: corrupted start while seeking, then lock on a clean stream
        wr(2'd0, 8'h00);
        m_err = 8'h00;
        for (int i = 0; i < 20; i++) bits(1, (i == 2 || i == 9 || i == 16));
        bits(80, 0);
        rd(2'd0, v);
        check("R4 bits in seek not counted", v, m_err);
        check("R4 model expects zero", m_err, 8'h00);

        // R3: isolated flipped bits each counted once
        for (int k = 0; k < 3; k++) begin
            bits(1, 1);
            bits(9, 0);
        end
        rd(2'd0, v);
        check("R3 three isolated errors", v, 8'h03);
        check("R2 lock reached", {7'd0, m_lock}, 8'h01);

        // R4: strobe low with wrong bits has no effect
        for (int i = 0; i < 6; i++) cyc(0, i[0], 0, 0, 0, 2'd0, 8'h00, v);
        rd(2'd0, v);
        check("R4 invalid strobes ignored", v, 8'h03);

        // R3: a burst of consecutive errors
        bits(4, 1);
        bits(5, 0);
        rd(2'd0, v);
        check("R3 burst of four", v, 8'h07);

        // R5 R7 R8: rollover sets flag, irq with mask
        wr(2'd3, 8'h01);
        wr(2'd0, 8'hFE);
        bits(1, 1);
        bits(1, 0);
        bits(1, 1);
        rd(2'd0, v);
        check("R5 error counter wraps to 00", v, 8'h00);
        check("R8 irq raised", {7'd0, irq}, 8'h01);
        rd(2'd2, v);
        check("R7 flag set, upper bits zero", v, 8'h01);
        rd(2'd2, v);
        check("R7 flag cleared by read", v, 8'h00);
        check("R8 irq dropped", {7'd0, irq}, 8'h00);

        // R8: masked flag, then unmask keeps flag
        wr(2'd3, 8'h00);
        wr(2'd0, 8'hFF);
        bits(1, 1);
        check("R8 masked irq low", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h01);
        check("R8 unmask exposes flag", {7'd0, irq}, 8'h01);
        rd(2'd2, v);
        check("R8 flag survived mask write", v, 8'h01);

        // R7: rollover in the same cycle as a clearing read
        wr(2'd0, 8'hFF);
        rd(2'd2, v);
        check("R7 flag clear before race", v, 8'h00);
        cyc(1, 1, 0, 0, 1, 2'd2, 8'h00, v);
        rd(2'd2, v);
        check("R7 set wins over read clear", v, 8'h01);
        rd(2'd2, v);
        check("R7 flag cleared after race", v, 8'h00);

        // R5: multiframe counting and wrap
        wr(2'd1, 8'hFF);
        cyc(0, 0, 1, 0, 0, 2'd0, 8'h00, v);
        rd(2'd1, v);
        check("R5 multiframe wraps", v, 8'h00);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 2'd0, 8'h00, v);
        rd(2'd1, v);
        check("R5 multiframe counts three", v, 8'h03);

        // R6: write priority over same-cycle increments
        cyc(0, 0, 1, 1, 0, 2'd1, 8'h10, v);
        rd(2'd1, v);
        check("R6 load beats multiframe increment", v, 8'h10);
        cyc(0, 0, 1, 1, 0, 2'd0, 8'h44, v);
        rd(2'd1, v);
        check("R6 error write clears multiframe", v, 8'h00);
        cyc(1, 1, 0, 1, 0, 2'd0, 8'h20, v);
        rd(2'd0, v);
        check("R6 load beats error increment", v, 8'h20);

        // R1: reset again returns everything to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, v);
        check("R1 error counter after reset", v, 8'h00);
        rd(2'd3, v);
        check("R1 mask after reset", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule